// File: doc/BRIEF.md
# Cached dual stack controller

This block keeps two stacks in one shared word-addressed memory: an operand stack that grows toward higher addresses and a return stack that grows toward lower ones, so the free space between them is shared. Each stack has a pointer and a bottom register, and a small register cache in front of it holds the newest items. A push reaches memory only when it forces the oldest cached item out. A pop reaches memory only when the cache has nothing left to give.

A core drives push and pop strobes for either stack. The block drives a single memory port that does one access per cycle and returns pop results one cycle after the request. It also reports empty stacks, pointer collisions (overflow) and pops from empty stacks (underflow), and it raises an exception request that carries a fixed handler address. When both stacks need memory in the same cycle, the operand stack goes first. The return stack access follows in the next cycle, and a stall output holds the core off while it waits.

Top module: `dual_stack_cache`

## Requirements
- R1: After reset both pointers equal their reset bases (operand 0x0100, return 0x0200 by default), both empty flags are high, no memory access is requested and no exception is raised.
- R2: A push into a stack whose cache is not full issues no memory access and leaves the pointer unchanged. A pop served from a non-empty cache issues no memory access, and the cycle after the request it returns the newest item with its pop-valid high.
- R3: A push into a full cache writes the oldest cached item to memory. For the operand stack the address is pointer+1 and for the return stack it is pointer−1, and the pointer takes that address.
- R4: A pop on an empty cache with pointer ≠ bottom reads memory at the pointer. The word read is returned the cycle after the read is issued, with pop-valid high. The pointer moves one step back toward its bottom.
- R5: A stack's empty flag is high exactly when its cache holds nothing and its pointer equals its bottom register.
- R6: A pop on an empty stack issues no memory access, gives no pop-valid and changes no state. The cycle after the request, `exc_underflow` and `exc_req` are high for one cycle and `exc_addr` shows the EXC_ADDR parameter (default 0x0040).
- R7: A push that would spill to the address the other stack's pointer holds is refused: nothing is written, the pointer and cache keep their values, and `exc_overflow` with `exc_req` is high the next cycle.
- R8: At most one memory access is issued per cycle. When both stacks need memory in one cycle, the operand access is issued at once and the return access is issued the next cycle, and `stall` is high for exactly that one cycle.
- R9: Push and pop requests presented while `stall` is high are ignored.
- R10: A config write (`cfg_sel` 0 = operand stack, 1 = return stack) in a cycle with no request, no stall and no read in flight loads that stack's bottom and pointer from `cfg_base` and empties its cache. A config write in any other cycle is ignored.
- R11: Items come back in last-in-first-out order, whether they were served from the cache or from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ds_push | input | 1 | Push `ds_wdata` onto the operand stack |
| ds_pop | input | 1 | Pop the operand stack |
| ds_wdata | input | DW | Operand stack push data |
| rs_push | input | 1 | Push `rs_wdata` onto the return stack |
| rs_pop | input | 1 | Pop the return stack |
| rs_wdata | input | DW | Return stack push data |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 1 | Config target: 0 operand stack, 1 return stack |
| cfg_base | input | AW | New bottom and pointer value |
| ds_pop_valid | output | 1 | Operand pop result valid |
| ds_pop_data | output | DW | Operand pop result |
| rs_pop_valid | output | 1 | Return pop result valid |
| rs_pop_data | output | DW | Return pop result |
| ds_empty | output | 1 | Operand stack holds no items |
| rs_empty | output | 1 | Return stack holds no items |
| ds_ptr | output | AW | Operand stack pointer |
| rs_ptr | output | AW | Return stack pointer |
| stall | output | 1 | Deferred return access in progress; requests ignored |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_re` |
| exc_req | output | 1 | Exception request pulse |
| exc_overflow | output | 1 | Cause: stack collision |
| exc_underflow | output | 1 | Cause: pop of an empty stack |
| exc_addr | output | AW | Exception handler address |

## Verification
The bench fills each cache past its depth and drains it again. A design that spills the newest item instead of the oldest, or steps the pointer the wrong way, would return items out of order or write to the wrong addresses. It brings the operand stack up against the return pointer: a design that compares before it steps would write over the return stack's top word, or would keep the refused item. It makes both stacks miss in the same cycle: a wrong arbiter would drive two accesses at once, would lose the deferred return access, or would accept a push made during the stall. It also pops empty stacks and sends config writes on busy cycles, where a faulty design would read memory, move a pointer or take the new base.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
// dsc_pkg: shared types of the cached dual stack controller.
package dsc_pkg;

    // Identifies which stack owns a memory access.
    typedef enum logic {
        DSC_OPND = 1'b0,
        DSC_RET  = 1'b1
    } dsc_side_e;

endpackage

// File: rtl/dsc_lifo_cache.sv
`timescale 1ns/1ps
// dsc_lifo_cache: register cache holding the newest DEPTH items of one stack.
// Entry 0 is the newest. A push into a full cache drops the oldest entry;
// the owner reads that entry through `oldest` in the same cycle and spills it.
// Assumes push and pop are never high together, and pop only when not empty.
module dsc_lifo_cache #(
    parameter int DW    = 16,
    parameter int DEPTH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] top,
    output logic [DW-1:0] oldest,
    output logic          full,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] ent [DEPTH];
    logic [CW-1:0] count;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign top    = ent[0];
    assign oldest = ent[DEPTH-1];

    // Occupancy count: grows to DEPTH on pushes, shrinks on pops.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CW'(1);
        end else if (pop && !empty) begin
            count <= count - CW'(1);
        end
    end

    // Entry shift network: push shifts toward the old end, pop toward the new.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0 && DEPTH == 1) begin : g_single
            // Lone entry: push overwrites, pop leaves the stale value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= din;
                end
            end
        end else if (i == 0) begin : g_head
            // Newest entry: takes din on push, next-older entry on pop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= din;
                end else if (pop) begin
                    ent[i] <= ent[i+1];
                end
            end
        end else if (i == DEPTH - 1) begin : g_tail
            // Oldest entry: takes next-newer entry on push, holds on pop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= ent[i-1];
                end
            end
        end else begin : g_mid
            // Middle entry: shifts either way.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= ent[i-1];
                end else if (pop) begin
                    ent[i] <= ent[i+1];
                end
            end
        end
    end
endmodule

// File: rtl/dsc_stack_side.sv
`timescale 1ns/1ps
// dsc_stack_side: pointer, bottom register and cache of one stack.
// GROW_UP selects the growth direction. The side works out its memory need,
// its overflow and underflow conditions, and its next pointer in the cycle of
// the request. Overflow compares the spill address with the peer pointer.
// Assumes push and pop are never high together on the same stack.
module dsc_stack_side #(
    parameter int          AW      = 16,
    parameter int          DW      = 16,
    parameter int          DEPTH   = 1,
    parameter bit          GROW_UP = 1'b1,
    parameter logic [15:0] BASE    = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] peer_ptr,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt,
    output logic          empty,
    output logic          need,
    output logic          req_we,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic          ovf,
    output logic          unf,
    output logic          hit_valid,
    output logic [DW-1:0] hit_data
);
    logic [AW-1:0] bot;
    logic [AW-1:0] step_out;
    logic [AW-1:0] step_in;
    logic          spill;
    logic          miss;
    logic          c_full;
    logic          c_empty;
    logic [DW-1:0] c_top;
    logic [DW-1:0] c_oldest;

    dsc_lifo_cache #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cfg_load),
        .push   (push && !ovf),
        .pop    (pop && !c_empty),
        .din    (wdata),
        .top    (c_top),
        .oldest (c_oldest),
        .full   (c_full),
        .empty  (c_empty)
    );

    // Direction-dependent neighbour addresses of the pointer.
    always_comb begin
        if (GROW_UP) begin
            step_out = ptr + AW'(1);
            step_in  = ptr - AW'(1);
        end else begin
            step_out = ptr - AW'(1);
            step_in  = ptr + AW'(1);
        end
    end

    // Request classification: spill on full push, refill on empty pop.
    always_comb begin
        spill     = push && c_full;
        miss      = pop && c_empty;
        ovf       = spill && (step_out == peer_ptr);
        unf       = miss && (ptr == bot);
        need      = (spill && !ovf) || (miss && !unf);
        req_we    = spill;
        req_addr  = spill ? step_out : ptr;
        req_wdata = c_oldest;
        empty     = c_empty && (ptr == bot);
    end

    // Next pointer: config load, outward step on spill, inward step on refill.
    always_comb begin
        if (cfg_load) begin
            ptr_nxt = cfg_base;
        end else if (spill && !ovf) begin
            ptr_nxt = step_out;
        end else if (miss && !unf) begin
            ptr_nxt = step_in;
        end else begin
            ptr_nxt = ptr;
        end
    end

    // Pointer and bottom registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= AW'(BASE);
            bot <= AW'(BASE);
        end else begin
            ptr <= ptr_nxt;
            if (cfg_load) begin
                bot <= cfg_base;
            end
        end
    end

    // Registered result of a pop served from the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit_data  <= '0;
        end else begin
            hit_valid <= pop && !c_empty;
            hit_data  <= c_top;
        end
    end
endmodule

// File: rtl/dsc_mem_arb.sv
`timescale 1ns/1ps
// dsc_mem_arb: single memory port shared by the two stacks.
// The operand stack wins a same-cycle conflict. The return access is parked
// and issued the next cycle while `stall` is high. Assumes no new needs
// arrive while stall is high (the top gates requests). Tracks which stack
// owns a read so that the read data, arriving one cycle later, reaches it.
module dsc_mem_arb
    import dsc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ds_need,
    input  logic          ds_we,
    input  logic [AW-1:0] ds_addr,
    input  logic [DW-1:0] ds_wdata,
    input  logic          rs_need,
    input  logic          rs_we,
    input  logic [AW-1:0] rs_addr,
    input  logic [DW-1:0] rs_wdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          stall,
    output logic          rd_ds_q,
    output logic          rd_rs_q
);
    logic          pend_v;
    logic          pend_we;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic          issue;
    logic          issue_we;
    dsc_side_e     owner;

    assign stall = pend_v;

    // Port selection: parked access first, then operand, then return.
    always_comb begin
        issue     = 1'b0;
        issue_we  = 1'b0;
        owner     = DSC_OPND;
        mem_addr  = '0;
        mem_wdata = '0;
        if (pend_v) begin
            issue     = 1'b1;
            issue_we  = pend_we;
            owner     = DSC_RET;
            mem_addr  = pend_addr;
            mem_wdata = pend_data;
        end else if (ds_need) begin
            issue     = 1'b1;
            issue_we  = ds_we;
            owner     = DSC_OPND;
            mem_addr  = ds_addr;
            mem_wdata = ds_wdata;
        end else if (rs_need) begin
            issue     = 1'b1;
            issue_we  = rs_we;
            owner     = DSC_RET;
            mem_addr  = rs_addr;
            mem_wdata = rs_wdata;
        end
        mem_re = issue && !issue_we;
        mem_we = issue && issue_we;
    end

    // Parking register for the losing return-stack access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_we   <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (!pend_v && ds_need && rs_need) begin
            pend_v    <= 1'b1;
            pend_we   <= rs_we;
            pend_addr <= rs_addr;
            pend_data <= rs_wdata;
        end else begin
            pend_v    <= 1'b0;
        end
    end

    // Read ownership tags, aligned with the memory's one-cycle read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ds_q <= 1'b0;
            rd_rs_q <= 1'b0;
        end else begin
            rd_ds_q <= mem_re && (owner == DSC_OPND);
            rd_rs_q <= mem_re && (owner == DSC_RET);
        end
    end
endmodule

// File: rtl/dual_stack_cache.sv
`timescale 1ns/1ps
// dual_stack_cache: operand and return stacks in one shared memory, each with
// a register cache. The operand stack grows up from its bottom and the return
// stack grows down from its bottom. Memory is touched only on spill or
// refill. Assumes a memory with one-cycle read latency, and push and pop
// never high together on the same stack.
module dual_stack_cache #(
    parameter int          AW       = 16,
    parameter int          DW       = 16,
    parameter int          DEPTH    = 1,
    parameter logic [15:0] DS_BASE  = 16'h0100,
    parameter logic [15:0] RS_BASE  = 16'h0200,
    parameter logic [15:0] EXC_ADDR = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ds_push,
    input  logic          ds_pop,
    input  logic [DW-1:0] ds_wdata,
    input  logic          rs_push,
    input  logic          rs_pop,
    input  logic [DW-1:0] rs_wdata,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_base,
    output logic          ds_pop_valid,
    output logic [DW-1:0] ds_pop_data,
    output logic          rs_pop_valid,
    output logic [DW-1:0] rs_pop_data,
    output logic          ds_empty,
    output logic          rs_empty,
    output logic [AW-1:0] ds_ptr,
    output logic [AW-1:0] rs_ptr,
    output logic          stall,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          exc_req,
    output logic          exc_overflow,
    output logic          exc_underflow,
    output logic [AW-1:0] exc_addr
);
    logic          ds_push_g, ds_pop_g, rs_push_g, rs_pop_g;
    logic          idle;
    logic          ds_cfg, rs_cfg;
    logic [AW-1:0] ds_ptr_nxt, rs_ptr_nxt;
    logic          ds_need, rs_need;
    logic          ds_req_we, rs_req_we;
    logic [AW-1:0] ds_req_addr, rs_req_addr;
    logic [DW-1:0] ds_req_wdata, rs_req_wdata;
    logic          ds_ovf, rs_ovf, ds_unf, rs_unf;
    logic          ds_hit_v, rs_hit_v;
    logic [DW-1:0] ds_hit_d, rs_hit_d;
    logic          rd_ds_q, rd_rs_q;

    // Request gating while a parked access drains, and config acceptance.
    always_comb begin
        ds_push_g = ds_push && !stall;
        ds_pop_g  = ds_pop  && !stall;
        rs_push_g = rs_push && !stall;
        rs_pop_g  = rs_pop  && !stall;
        idle      = !stall && !rd_ds_q && !rd_rs_q &&
                    !(ds_push || ds_pop || rs_push || rs_pop);
        ds_cfg    = cfg_we && idle && !cfg_sel;
        rs_cfg    = cfg_we && idle &&  cfg_sel;
    end

    dsc_stack_side #(
        .AW      (AW),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .GROW_UP (1'b1),
        .BASE    (DS_BASE)
    ) u_ds (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ds_push_g),
        .pop       (ds_pop_g),
        .wdata     (ds_wdata),
        .cfg_load  (ds_cfg),
        .cfg_base  (cfg_base),
        .peer_ptr  (rs_ptr),
        .ptr       (ds_ptr),
        .ptr_nxt   (ds_ptr_nxt),
        .empty     (ds_empty),
        .need      (ds_need),
        .req_we    (ds_req_we),
        .req_addr  (ds_req_addr),
        .req_wdata (ds_req_wdata),
        .ovf       (ds_ovf),
        .unf       (ds_unf),
        .hit_valid (ds_hit_v),
        .hit_data  (ds_hit_d)
    );

    // The return side checks collisions against the operand pointer after
    // this cycle's operand update, so both stacks cannot target one word.
    dsc_stack_side #(
        .AW      (AW),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .GROW_UP (1'b0),
        .BASE    (RS_BASE)
    ) u_rs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rs_push_g),
        .pop       (rs_pop_g),
        .wdata     (rs_wdata),
        .cfg_load  (rs_cfg),
        .cfg_base  (cfg_base),
        .peer_ptr  (ds_ptr_nxt),
        .ptr       (rs_ptr),
        .ptr_nxt   (rs_ptr_nxt),
        .empty     (rs_empty),
        .need      (rs_need),
        .req_we    (rs_req_we),
        .req_addr  (rs_req_addr),
        .req_wdata (rs_req_wdata),
        .ovf       (rs_ovf),
        .unf       (rs_unf),
        .hit_valid (rs_hit_v),
        .hit_data  (rs_hit_d)
    );

    dsc_mem_arb #(
        .AW (AW),
        .DW (DW)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ds_need   (ds_need),
        .ds_we     (ds_req_we),
        .ds_addr   (ds_req_addr),
        .ds_wdata  (ds_req_wdata),
        .rs_need   (rs_need),
        .rs_we     (rs_req_we),
        .rs_addr   (rs_req_addr),
        .rs_wdata  (rs_req_wdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .stall     (stall),
        .rd_ds_q   (rd_ds_q),
        .rd_rs_q   (rd_rs_q)
    );

    // Pop results: memory data when a refill read lands, else the cache hit.
    always_comb begin
        ds_pop_valid = ds_hit_v || rd_ds_q;
        ds_pop_data  = rd_ds_q ? mem_rdata : ds_hit_d;
        rs_pop_valid = rs_hit_v || rd_rs_q;
        rs_pop_data  = rd_rs_q ? mem_rdata : rs_hit_d;
        exc_addr     = AW'(EXC_ADDR);
    end

    // Exception cause flags, one cycle after the offending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_overflow  <= 1'b0;
            exc_underflow <= 1'b0;
        end else begin
            exc_overflow  <= ds_ovf || rs_ovf;
            exc_underflow <= ds_unf || rs_unf;
        end
    end

    assign exc_req = exc_overflow || exc_underflow;
endmodule

// File: rtl/dsc_checker.sv
`timescale 1ns/1ps
// dsc_checker: temporal properties of dual_stack_cache, bound to the top.
module dsc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ds_push,
    input logic          ds_pop,
    input logic          cfg_we,
    input logic          stall,
    input logic          mem_re,
    input logic          mem_we,
    input logic          ds_empty,
    input logic          ds_pop_valid,
    input logic          exc_underflow,
    input logic [AW-1:0] ds_ptr,
    input logic [AW-1:0] rs_ptr
);
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R8

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R8

    AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (mem_re || mem_we)); // R9

    AST_UNDERFLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_pop && !ds_push && !stall && ds_empty) |=> (exc_underflow && !ds_pop_valid)); // R6

    AST_PTR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_re && !mem_we && !cfg_we) |=> ($stable(ds_ptr) && $stable(rs_ptr))); // R3

    AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_pop && !ds_push && !stall && !ds_empty) |=> ds_pop_valid); // R2
endmodule

bind dual_stack_cache dsc_checker #(.AW(AW)) u_dsc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ds_push       (ds_push),
    .ds_pop        (ds_pop),
    .cfg_we        (cfg_we),
    .stall         (stall),
    .mem_re        (mem_re),
    .mem_we        (mem_we),
    .ds_empty      (ds_empty),
    .ds_pop_valid  (ds_pop_valid),
    .exc_underflow (exc_underflow),
    .ds_ptr        (ds_ptr),
    .rs_ptr        (rs_ptr)
);

// File: tb/dual_stack_cache_bench.sv
`timescale 1ns/1ps
// Directed bench for dual_stack_cache with a one-cycle-latency memory model.
module dual_stack_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ds_push = 0, ds_pop = 0, rs_push = 0, rs_pop = 0;
    logic [15:0] ds_wdata = '0, rs_wdata = '0;
    logic        cfg_we = 0, cfg_sel = 0;
    logic [15:0] cfg_base = '0;
    logic        ds_pop_valid, rs_pop_valid, ds_empty, rs_empty, stall;
    logic [15:0] ds_pop_data, rs_pop_data, ds_ptr, rs_ptr;
    logic        mem_re, mem_we;
    logic [15:0] mem_addr, mem_wdata, exc_addr;
    logic [15:0] mem_rdata = '0;
    logic        exc_req, exc_overflow, exc_underflow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic        cm_re, cm_we;
    logic [15:0] cm_addr, cm_wd;
    logic [15:0] mem [1024];

    always #2.5 clk = ~clk;

    dual_stack_cache u_dual_stack_cache (
        .clk(clk), .rst_n(rst_n),
        .ds_push(ds_push), .ds_pop(ds_pop), .ds_wdata(ds_wdata),
        .rs_push(rs_push), .rs_pop(rs_pop), .rs_wdata(rs_wdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .ds_pop_valid(ds_pop_valid), .ds_pop_data(ds_pop_data),
        .rs_pop_valid(rs_pop_valid), .rs_pop_data(rs_pop_data),
        .ds_empty(ds_empty), .rs_empty(rs_empty),
        .ds_ptr(ds_ptr), .rs_ptr(rs_ptr), .stall(stall),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .exc_req(exc_req), .exc_overflow(exc_overflow),
        .exc_underflow(exc_underflow), .exc_addr(exc_addr)
    );

    // Memory model: synchronous write, read data one cycle after mem_re.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request cycle: drive at a negedge, capture the memory request,
    // then release at the next negedge where registered results are visible.
    task automatic op(input logic dpu, input logic dpo, input logic rpu, input logic rpo,
                      input logic [15:0] dw, input logic [15:0] rw,
                      input logic cwe = 1'b0, input logic csel = 1'b0,
                      input logic [15:0] cb = 16'h0);
        @(negedge clk);
        ds_push = dpu; ds_pop = dpo; rs_push = rpu; rs_pop = rpo;
        ds_wdata = dw; rs_wdata = rw;
        cfg_we = cwe; cfg_sel = csel; cfg_base = cb;
        #1;
        cm_re = mem_re; cm_we = mem_we; cm_addr = mem_addr; cm_wd = mem_wdata;
        @(negedge clk);
        ds_push = 0; ds_pop = 0; rs_push = 0; rs_pop = 0; cfg_we = 0;
    endtask

    task automatic t_reset();
        check("R1 ds_ptr", ds_ptr, 16'h0100);
        check("R1 rs_ptr", rs_ptr, 16'h0200);
        check("R1 empties", {ds_empty, rs_empty}, 2'b11);
        check("R1 no access", {mem_re, mem_we, exc_req}, 3'b000);
    endtask

    task automatic t_cache_hit();
        op(1, 0, 0, 0, 16'hC0DE, 0);
        check("R2 push no access", {cm_re, cm_we}, 2'b00);
        check("R2 ptr held", ds_ptr, 16'h0100);
        check("R5 not empty", ds_empty, 1'b0);
        op(0, 1, 0, 0, 0, 0);
        check("R2 pop no access", {cm_re, cm_we}, 2'b00);
        check("R2 pop valid", ds_pop_valid, 1'b1);
        check("R2 pop data", ds_pop_data, 16'hC0DE);
        check("R5 empty again", ds_empty, 1'b1);
    endtask

    task automatic t_spill_refill();
        op(1, 0, 0, 0, 16'h1111, 0);
        op(1, 0, 0, 0, 16'h2222, 0);
        check("R3 spill write", {cm_we, cm_addr, cm_wd}, {1'b1, 16'h0101, 16'h1111});
        check("R3 ds ptr up", ds_ptr, 16'h0101);
        op(1, 0, 0, 0, 16'h3333, 0);
        check("R3 spill addr", {cm_addr, cm_wd}, {16'h0102, 16'h2222});
        check("R5 ptr off bottom", ds_empty, 1'b0);
        op(0, 1, 0, 0, 0, 0);
        check("R11 newest first", {ds_pop_valid, ds_pop_data}, {1'b1, 16'h3333});
        op(0, 1, 0, 0, 0, 0);
        check("R4 refill read", {cm_re, cm_addr}, {1'b1, 16'h0102});
        check("R11 second", {ds_pop_valid, ds_pop_data}, {1'b1, 16'h2222});
        check("R4 ds ptr down", ds_ptr, 16'h0101);
        op(0, 1, 0, 0, 0, 0);
        check("R11 oldest last", {ds_pop_data, ds_ptr}, {16'h1111, 16'h0100});
        check("R5 drained", ds_empty, 1'b1);
        op(0, 0, 1, 0, 0, 16'hAAAA);
        op(0, 0, 1, 0, 0, 16'hBBBB);
        check("R3 rs spill down", {cm_we, cm_addr, cm_wd, rs_ptr},
              {1'b1, 16'h01FF, 16'hAAAA, 16'h01FF});
        op(0, 0, 0, 1, 0, 0);
        check("R11 rs hit", {rs_pop_valid, rs_pop_data}, {1'b1, 16'hBBBB});
        op(0, 0, 0, 1, 0, 0);
        check("R4 rs refill", {cm_re, cm_addr, rs_pop_data, rs_ptr},
              {1'b1, 16'h01FF, 16'hAAAA, 16'h0200});
    endtask

    task automatic t_underflow();
        op(0, 1, 0, 0, 0, 0);
        check("R6 no access", {cm_re, cm_we}, 2'b00);
        check("R6 flags", {exc_underflow, exc_req, exc_overflow, ds_pop_valid}, 4'b1100);
        check("R6 handler", exc_addr, 16'h0040);
        check("R6 ptr held", ds_ptr, 16'h0100);
        @(negedge clk);
        check("R6 pulse ends", exc_req, 1'b0);
        op(0, 0, 0, 1, 0, 0);
        check("R6 rs underflow", {exc_underflow, rs_pop_valid, rs_ptr}, {1'b1, 1'b0, 16'h0200});
    endtask

    task automatic t_overflow();
        op(0, 0, 0, 0, 0, 0, 1, 0, 16'h01FD);
        check("R10 cfg load", {ds_ptr, ds_empty}, {16'h01FD, 1'b1});
        op(1, 0, 0, 0, 16'hA001, 0);
        op(1, 0, 0, 0, 16'hA002, 0);
        op(1, 0, 0, 0, 16'hA003, 0);
        check("R3 near top", {cm_addr, ds_ptr}, {16'h01FF, 16'h01FF});
        op(1, 0, 0, 0, 16'hA004, 0);
        check("R7 no write", cm_we, 1'b0);
        check("R7 flags", {exc_overflow, exc_req}, 2'b11);
        check("R7 ptr held", ds_ptr, 16'h01FF);
        op(0, 1, 0, 0, 0, 0);
        check("R7 push refused", ds_pop_data, 16'hA003);
        op(0, 0, 0, 0, 0, 0, 1, 0, 16'h0100);
    endtask

    task automatic t_conflict();
        op(1, 0, 1, 0, 16'h5001, 16'h6001);
        @(negedge clk);
        ds_push = 1; rs_push = 1; ds_wdata = 16'h5002; rs_wdata = 16'h6002;
        #1;
        check("R8 ds first", {mem_we, mem_re, mem_addr, mem_wdata}, {2'b10, 16'h0101, 16'h5001});
        @(negedge clk);
        rs_push = 0; ds_wdata = 16'h7777;
        #1;
        check("R8 stall", stall, 1'b1);
        check("R8 rs deferred", {mem_we, mem_re, mem_addr, mem_wdata}, {2'b10, 16'h01FF, 16'h6001});
        @(negedge clk);
        ds_push = 0;
        check("R8 stall one cycle", stall, 1'b0);
        check("R9 ptrs", {ds_ptr, rs_ptr}, {16'h0101, 16'h01FF});
        @(negedge clk);
        ds_pop = 1; rs_pop = 1;
        @(negedge clk);
        check("R9 ignored push", {ds_pop_valid, ds_pop_data}, {1'b1, 16'h5002});
        check("R11 rs hit", rs_pop_data, 16'h6002);
        #1;
        check("R8 ds read first", {mem_re, mem_addr}, {1'b1, 16'h0101});
        @(negedge clk);
        ds_pop = 0; rs_pop = 0;
        check("R4 ds refill", {ds_pop_valid, ds_pop_data, stall}, {1'b1, 16'h5001, 1'b1});
        #1;
        check("R8 rs read next", {mem_re, mem_addr}, {1'b1, 16'h01FF});
        @(negedge clk);
        check("R4 rs late data", {rs_pop_valid, rs_pop_data, ds_pop_valid}, {1'b1, 16'h6001, 1'b0});
        check("R5 both empty", {ds_empty, rs_empty, ds_ptr, rs_ptr}, {2'b11, 16'h0100, 16'h0200});
    endtask

    task automatic t_config();
        op(1, 0, 0, 0, 16'h9999, 0, 1, 0, 16'h0300);
        check("R10 busy cfg ignored", {ds_ptr, ds_empty}, {16'h0100, 1'b0});
        op(0, 0, 0, 0, 0, 0, 1, 0, 16'h0100);
        check("R10 cfg clears cache", ds_empty, 1'b1);
        op(0, 0, 0, 0, 0, 0, 1, 1, 16'h0280);
        check("R10 rs cfg", {rs_ptr, rs_empty, ds_ptr}, {16'h0280, 1'b1, 16'h0100});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cache_hit();
        t_spill_refill();
        t_underflow();
        t_overflow();
        t_conflict();
        t_config();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule